// File: doc/BRIEF.md
# Tightly-Coupled Memory Sequential-Request Slave

This block is a zero-wait-state slave that sits between a processor's tightly coupled memory port and a synchronous single-port word array held inside the block. In every clock cycle the processor may present one request. A request consists of a select, a read strobe, a flag that marks the access as the successor of the previous one, and a word address. The read data comes back registered, exactly one clock later. A valid output marks that return cycle, so a new request can overlap the return of the previous one and the port sustains one access per clock.

The slave remembers the address of the most recent request, so that it can check the sequential flag. When the flag is set and the address is not the remembered address plus one, it raises a one-cycle protocol-error pulse. It also raises the pulse when the flag comes before any request since reset, and, under the data-side rules, when the flag follows an idle cycle.

A parameter selects one of two sets of rules. Instruction-side rules make the port read-only and keep the remembered address across any number of idle cycles. Data-side rules accept byte-lane writes and allow a sequential flag only directly after a request.

Top module: `tcm_slave`

## Requirements
- R1: A read request (reqSel=1, reqRd=1, and no write) at address A makes rspValid high in the next cycle, with rspData equal to the word stored at A.
- R2: Read requests in consecutive cycles are each returned one cycle later, so that rspValid stays high for every cycle that follows a read.
- R3: In a cycle that follows a cycle with no request, rspValid is low.
- R4: A request with reqSeq=0 never raises protoErr, whatever its address.
- R5: A request with reqSeq=1 whose address differs from the remembered address plus one (modulo 2^ADDR_W) makes protoErr high for the next cycle. A request with reqSeq=1 at exactly that address, including the wrap from the top address to 0, raises no error under instruction-side rules.
- R6: A request with reqSeq=1 before any request since reset makes protoErr high for the next cycle.
- R7: Under instruction-side rules (DATA_SIDE=0), the remembered address persists across idle cycles. A correct sequential request after any number of idle cycles raises no error.
- R8: Under data-side rules (DATA_SIDE=1), a request with reqSeq=1 that follows an idle cycle makes protoErr high for the next cycle, even when its address is correct.
- R9: Under data-side rules, reqSel=1 with reqWe=1 writes reqWdata into the word at reqAddr at that clock edge. Bit i of reqLanes enables data bits 8i+7 down to 8i. The write takes priority over reqRd, and rspValid is low in the next cycle.
- R10: Under instruction-side rules, reqWe is ignored: the array keeps its contents, so a later read of that address returns the old word (zero after power-up).
- R11: While rst is high at a clock edge, rspValid and protoErr go low after that edge and the remembered address is forgotten. The array starts at all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqSel | input | 1 | Request present this cycle |
| reqRd | input | 1 | Request is a read |
| reqSeq | input | 1 | Request claims to follow the previous one |
| reqAddr | input | ADDR_W | Word address |
| reqWe | input | 1 | Write enable (data-side rules only) |
| reqWdata | input | DATA_W | Write data |
| reqLanes | input | DATA_W/8 | Byte-lane write enables |
| rspData | output | DATA_W | Read data, valid when rspValid is high |
| rspValid | output | 1 | High in the cycle after an accepted read |
| protoErr | output | 1 | One-cycle pulse after a misused sequential flag |

## Verification
The assertions assume that the request inputs are settled at each rising edge and that reqWe, reqRd and reqSeq are ignored when reqSel is low. They also assume that DATA_W is a whole number of bytes. The bench changes every input on the falling clock edge, drives idle cycles with reqSel low, and feeds one shared stimulus to an instruction-side instance and a data-side instance at the same time. This lets the same sequence show where the two sets of rules agree and where they differ: sequential requests after idle cycles, and ignored or honoured writes.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  // Strobes from the control unit to the datapath, one set per cycle
  typedef struct packed {
    logic doRead;
    logic doWrite;
  } tcmStrobe_t;
endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
#(
  parameter int  ADDR_W    = 8,
  parameter bit  DATA_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqSel,
  input  logic              reqRd,
  input  logic              reqSeq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWe,
  output tcmStrobe_t        strobe,
  output logic              rspValid,
  output logic              protoErr
);
  logic [ADDR_W-1:0] lastAddr;
  logic              lastValid;
  logic              prevReq;
  logic [ADDR_W-1:0] expectAddr;
  logic              badSeq;
  logic              isWrite;

  assign expectAddr = lastAddr + ADDR_W'(1);

  // A write exists only under data-side rules and wins over a read
  assign isWrite = DATA_SIDE && reqSel && reqWe;

  always_comb begin
    strobe.doWrite = isWrite;
    strobe.doRead  = reqSel && reqRd && !isWrite;
  end

  // Misuse of the sequential flag
  always_comb begin
    badSeq = 1'b0;
    if (reqSel && reqSeq) begin
      if (!lastValid)                   badSeq = 1'b1;
      else if (reqAddr != expectAddr)   badSeq = 1'b1;
      else if (DATA_SIDE && !prevReq)   badSeq = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr  <= '0;
      lastValid <= 1'b0;
      prevReq   <= 1'b0;
      rspValid  <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      prevReq  <= reqSel;
      rspValid <= strobe.doRead;
      protoErr <= badSeq;
      if (reqSel) begin
        lastAddr  <= reqAddr;
        lastValid <= 1'b1;
      end
    end
  end

  AST_NONSEQ_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (reqSel && !reqSeq) |=> !protoErr);  // R4

  AST_FIRST_SEQ_ERR: assert property (@(posedge clk) disable iff (rst)
    (reqSel && reqSeq && !lastValid) |=> protoErr);  // R6

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    protoErr |-> $past(reqSel && reqSeq));  // R5

  AST_DSIDE_IDLE_SEQ: assert property (@(posedge clk) disable iff (rst)
    (DATA_SIDE && reqSel && reqSeq && !prevReq) |=> protoErr);  // R8

  AST_ISIDE_KEEP_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!DATA_SIDE && !reqSel) |=> $stable(lastAddr));  // R7
endmodule

// File: rtl/tcm_dpath.sv
module tcm_dpath
  import tcm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  tcmStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W/8-1:0] reqLanes,
  output logic [DATA_W-1:0] rspData
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][7:0] rdLanes;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) laneMem[i] = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (strobe.doWrite && reqLanes[g])
        laneMem[reqAddr] <= reqWdata[8*g +: 8];
      if (strobe.doRead)
        rdLanes[g] <= laneMem[reqAddr];
    end
  end

  assign rspData = rdLanes;

  initial begin
    AST_WHOLE_BYTES: assert (DATA_W % 8 == 0);  // R9
  end
endmodule

// File: rtl/tcm_slave.sv
module tcm_slave
  import tcm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit DATA_SIDE = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqSel,
  input  logic                reqRd,
  input  logic                reqSeq,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWe,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqLanes,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspValid,
  output logic                protoErr
);
  tcmStrobe_t strobe;

  tcm_ctrl #(.ADDR_W(ADDR_W), .DATA_SIDE(DATA_SIDE)) u_ctrl (
    .clk(clk), .rst(rst), .reqSel(reqSel), .reqRd(reqRd), .reqSeq(reqSeq),
    .reqAddr(reqAddr), .reqWe(reqWe), .strobe(strobe),
    .rspValid(rspValid), .protoErr(protoErr)
  );

  tcm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLanes(reqLanes), .rspData(rspData)
  );

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (reqSel && reqRd && !(DATA_SIDE && reqWe)) |=> rspValid);  // R1

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    !reqSel |=> !rspValid);  // R3

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (DATA_SIDE && reqSel && reqWe) |=> !rspValid);  // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rspValid && !protoErr));  // R11
endmodule

// File: tb/tcm_slave_tb.sv
module tcm_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqSel = 0, reqRd = 0, reqSeq = 0, reqWe = 0;
  logic [7:0]  reqAddr = 0;
  logic [31:0] reqWdata = 0;
  logic [3:0]  reqLanes = 0;
  logic [31:0] iData, dData;
  logic        iValid, iErr, dValid, dErr;

  always #2.5 clk = ~clk;

  tcm_slave #(.ADDR_W(8), .DATA_W(32), .DATA_SIDE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .reqSel(reqSel), .reqRd(reqRd), .reqSeq(reqSeq),
    .reqAddr(reqAddr), .reqWe(reqWe), .reqWdata(reqWdata), .reqLanes(reqLanes),
    .rspData(iData), .rspValid(iValid), .protoErr(iErr));

  tcm_slave #(.ADDR_W(8), .DATA_W(32), .DATA_SIDE(1'b1)) u_dutD (
    .clk(clk), .rst(rst), .reqSel(reqSel), .reqRd(reqRd), .reqSeq(reqSeq),
    .reqAddr(reqAddr), .reqWe(reqWe), .reqWdata(reqWdata), .reqLanes(reqLanes),
    .rspData(dData), .rspValid(dValid), .protoErr(dErr));

  typedef struct {
    bit          iv; bit ie; bit dv; bit de;
    logic [31:0] dd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  // Reference state
  logic [31:0] refMem [256];
  logic [7:0]  lastA [2];
  bit          lastV [2];
  bit          prevR [2];

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic bit seqBad(input int m, input logic s, input logic sq, input logic [7:0] a);
    if (!(s && sq)) return 1'b0;
    if (!lastV[m]) return 1'b1;
    if (a != lastA[m] + 8'd1) return 1'b1;
    if (m == 1 && !prevR[m]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cyc(input logic s, input logic r, input logic sq, input logic [7:0] a,
                     input logic w, input logic [31:0] wd, input logic [3:0] ln, input string tag);
    exp_t e;
    @(negedge clk);
    rst = 0; reqSel = s; reqRd = r; reqSeq = sq; reqAddr = a;
    reqWe = w; reqWdata = wd; reqLanes = ln;
    e.tag = tag;
    e.iv = s && r;
    e.ie = seqBad(0, s, sq, a);
    e.dv = s && r && !w;
    e.de = seqBad(1, s, sq, a);
    e.dd = refMem[a];
    if (s && w)
      for (int i = 0; i < 4; i++) if (ln[i]) refMem[a][8*i +: 8] = wd[8*i +: 8];
    for (int m = 0; m < 2; m++) begin
      if (s) begin lastA[m] = a; lastV[m] = 1'b1; end
      prevR[m] = s;
    end
    q.push_back(e);
  endtask

  task automatic doReset(input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1; reqSel = 1; reqRd = 1; reqSeq = 1; reqAddr = 8'h10;
    e.tag = tag; e.iv = 0; e.ie = 0; e.dv = 0; e.de = 0; e.dd = 0;
    for (int m = 0; m < 2; m++) begin lastV[m] = 0; prevR[m] = 0; end
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 0, 32'h0, 4'h0, tag);
  endtask

  // Monitor: compare one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({31'b0, iValid}, {31'b0, e.iv}, {e.tag, " instr valid"});
        chk({31'b0, iErr},   {31'b0, e.ie}, {e.tag, " instr err"});
        chk({31'b0, dValid}, {31'b0, e.dv}, {e.tag, " data valid"});
        chk({31'b0, dErr},   {31'b0, e.de}, {e.tag, " data err"});
        if (e.iv) chk(iData, 32'h0, {e.tag, " instr rdata"});
        if (e.dv) chk(dData, e.dd, {e.tag, " data rdata"});
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 32'h0;
    doReset("R11 reset");
    doReset("R11 reset");
    cyc(1, 1, 1, 8'h05, 0, 32'h0, 4'h0, "R6 seq first");
    cyc(1, 0, 0, 8'h0A, 1, 32'hAABBCCDD, 4'hF, "R9 full write");
    cyc(1, 0, 1, 8'h0B, 1, 32'h01020304, 4'hF, "R9 seq write");
    cyc(1, 0, 1, 8'h0C, 1, 32'h55667788, 4'hF, "R9 seq write");
    cyc(1, 0, 0, 8'h0A, 1, 32'h11223344, 4'h5, "R9 lane write");
    cyc(1, 1, 1, 8'h0A, 1, 32'hFFFFFFFF, 4'h0, "R5 R9 wrong seq write-wins");
    cyc(1, 1, 0, 8'h0A, 0, 32'h0, 4'h0, "R1 R10 read");
    cyc(1, 1, 1, 8'h0B, 0, 32'h0, 4'h0, "R2 seq read");
    cyc(1, 1, 1, 8'h0C, 0, 32'h0, 4'h0, "R2 seq read");
    idle("R3 idle");
    idle("R3 idle");
    idle("R7 idle");
    cyc(1, 1, 1, 8'h0D, 0, 32'h0, 4'h0, "R7 R8 seq after idle");
    cyc(1, 1, 1, 8'h14, 0, 32'h0, 4'h0, "R5 wrong addr");
    cyc(1, 1, 0, 8'h33, 0, 32'h0, 4'h0, "R4 nonseq jump");
    cyc(1, 1, 0, 8'hFF, 0, 32'h0, 4'h0, "R4 top addr");
    cyc(1, 1, 1, 8'h00, 0, 32'h0, 4'h0, "R5 wrap seq");
    cyc(1, 0, 1, 8'h01, 0, 32'h0, 4'h0, "R3 seq no read");
    idle("R3 idle");
    doReset("R11 reset again");
    cyc(1, 1, 1, 8'h02, 0, 32'h0, 4'h0, "R6 R11 seq after reset");
    cyc(1, 1, 0, 8'h0A, 0, 32'h0, 4'h0, "R1 read back");
    idle("R3 idle");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule